// File: doc/BRIEF.md
# Double-Buffered Transmit Message Swap Controller

This block looks after one transmit message buffer that has two halves. The host fills the commit half. The bus transmitter reads the transmit half. Each half is named only by an index that points into a shared data store. To hand a new message to the transmitter, the block exchanges the two indices and updates the per-half flags. No message data moves. The host drives enable, disable, lock and unlock requests and sets or clears the commit bit. The protocol engine reports slot boundaries, slot ownership and the end of each transmission.

A per-buffer mode input selects one of two commit modes. In streaming mode, a freshly committed message is held back until the message already on the transmit half has gone out at least once. In immediate mode, the exchange starts as soon as the buffer is usable and no transmission is in flight. The exchange occupies two clock cycles. Host state requests that meet an exchange are queued and applied afterwards. A transmission start beats an exchange start.

Top module: `tx_swap_buf`

## Requirements
- R1: After reset, the outputs are as follows. The buffer reports disabled=1 and locked=0. The commit bit, tx_cmt, tx_dval, tx_active, null_slot, xfer_busy and irq_flag are all 0. commit_idx is COMMIT_IDX_RST (0) and tx_idx is TX_IDX_RST (1).
- R2: host_commit_set and host_commit_clr change the commit bit only while the buffer is disabled or locked. host_access_ok is 1 in exactly those states. In any other state, both requests leave commit_cmt unchanged.
- R3: At the end of an exchange, commit_idx and tx_idx have traded values. In the same cycle, commit_cmt=0, irq_flag=1, tx_cmt=1 and tx_dval=0.
- R4: An exchange starts in the cycle after the registered state shows all of the following: enabled, unlocked, commit_cmt=1, tx_active=0 and the mode condition met. xfer_busy is then high for exactly two cycles. The indices trade at the second of these cycles.
- R5: In streaming mode (mode_immediate=0), no exchange starts while tx_cmt=1 and tx_dval=0. An empty transmit half (tx_cmt=0) does not block the exchange.
- R6: In immediate mode (mode_immediate=1), tx_dval does not gate the exchange. An exchange never starts while tx_active=1; it starts in the cycle after the transmission ends.
- R7: A disable or lock request is held, not applied, in two cases: when it arrives in the cycle an exchange starts, or while xfer_busy=1. It takes effect one cycle after xfer_busy falls.
- R8: Consider a cycle with slot_start=1 and slot_assigned=1. A message is available when tx_cmt=1, the buffer is enabled and no exchange is running. If a message is available, tx_active rises at the next edge. Otherwise null_slot pulses for one cycle.
- R9: Suppose a transmission start and an exchange start are both possible in the same cycle. The transmission starts and the exchange waits.
- R10: tx_done during a transmission clears tx_active and sets tx_dval.
- R11: Disabled and locked are separate status bits. Disable wins over a simultaneous enable, and lock wins over a simultaneous unlock.
- R12: irq_clr clears irq_flag. If an exchange sets the flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_immediate | input | 1 | 1 = immediate commit, 0 = streaming commit |
| host_commit_set | input | 1 | Host request to set the commit bit |
| host_commit_clr | input | 1 | Host request to clear the commit bit |
| host_enable | input | 1 | Host request to leave the disabled state |
| host_disable | input | 1 | Host request to disable the buffer |
| host_lock | input | 1 | Host request to lock the buffer |
| host_unlock | input | 1 | Host request to unlock the buffer |
| irq_clr | input | 1 | Clears the interrupt flag |
| slot_start | input | 1 | Slot boundary from the protocol engine |
| slot_assigned | input | 1 | The current slot belongs to this buffer |
| tx_done | input | 1 | Transmission of the transmit half finished |
| stat_disabled | output | 1 | Buffer disabled status |
| stat_locked | output | 1 | Buffer locked status |
| host_access_ok | output | 1 | Host may write commit-half data and the commit bit |
| commit_cmt | output | 1 | Commit bit of the commit half |
| commit_idx | output | IDX_W | Data slot index of the commit half |
| tx_cmt | output | 1 | Transmit half holds a committed message |
| tx_dval | output | 1 | Transmit half message has been sent at least once |
| tx_idx | output | IDX_W | Data slot index of the transmit half |
| tx_active | output | 1 | Transmission in progress |
| null_slot | output | 1 | Owned slot started with no message available |
| xfer_busy | output | 1 | Index exchange in progress |
| irq_flag | output | 1 | Commit-half interrupt flag |

## Verification
The bench sweeps both commit modes against two transmit-half histories: never sent and sent once. This shows that streaming mode alone waits on tx_dval, and that both modes proceed once the message has gone out. Separate sequences place a transmission over a pending immediate commit, and a slot start in the same cycle as a ready exchange. These separate the no-exchange-during-transmission rule from the transmission-first priority. Host requests are placed in the exchange start cycle and in its second cycle, with the expected one-cycle delay after xfer_busy falls. Paired opposite requests, and commits in an open state, confirm the status priorities and the commit guard.

// File: rtl/tx_swap_pkg.sv
package tx_swap_pkg;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_START = 2'd1,
        XF_END   = 2'd2
    } xfer_phase_e;

    typedef struct packed {
        logic dis;
        logic en;
        logic lock;
        logic unlock;
    } host_req_t;

endpackage

// File: rtl/tx_swap_hold.sv
module tx_swap_hold
    import tx_swap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  host_req_t req_i,
    input  logic      block_i,
    output host_req_t apply_o
);

    typedef struct packed {
        host_req_t pend;
    } hold_state_t;

    hold_state_t st_d, st_q;
    host_req_t   eff;

    always_comb begin
        st_d    = st_q;
        eff     = host_req_t'(req_i | st_q.pend);
        apply_o = '0;
        if (block_i) begin
            st_d.pend = eff;
        end else begin
            st_d.pend = '0;
            apply_o   = eff;
            if (eff.dis)  apply_o.en     = 1'b0;
            if (eff.lock) apply_o.unlock = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tx_swap_xfer.sv
module tx_swap_xfer
    import tx_swap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic swap_o
);

    typedef struct packed {
        xfer_phase_e phase;
    } xfer_state_t;

    xfer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            XF_IDLE:  if (start_i) st_d.phase = XF_START;
            XF_START: st_d.phase = XF_END;
            XF_END:   st_d.phase = XF_IDLE;
            default:  st_d.phase = XF_IDLE;
        endcase
    end

    assign busy_o = (st_q.phase != XF_IDLE);
    assign swap_o = (st_q.phase == XF_START);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: XF_IDLE};
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tx_swap_txside.sv
module tx_swap_txside (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_start_i,
    input  logic slot_assigned_i,
    input  logic tx_done_i,
    input  logic msg_avail_i,
    input  logic swap_i,
    output logic begin_o,
    output logic active_o,
    output logic dval_o,
    output logic null_o
);

    typedef struct packed {
        logic active;
        logic dval;
        logic nul;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic      owned;

    assign owned   = slot_start_i & slot_assigned_i;
    assign begin_o = owned & msg_avail_i & ~st_q.active;

    always_comb begin
        st_d     = st_q;
        st_d.nul = owned & ~begin_o;
        if (begin_o) begin
            st_d.active = 1'b1;
        end else if (tx_done_i && st_q.active) begin
            st_d.active = 1'b0;
            st_d.dval   = 1'b1;
        end
        if (swap_i) st_d.dval = 1'b0;
    end

    assign active_o = st_q.active;
    assign dval_o   = st_q.dval;
    assign null_o   = st_q.nul;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tx_swap_buf.sv
module tx_swap_buf
    import tx_swap_pkg::*;
#(
    parameter int IDX_W          = 4,
    parameter int COMMIT_IDX_RST = 0,
    parameter int TX_IDX_RST     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_immediate,
    input  logic             host_commit_set,
    input  logic             host_commit_clr,
    input  logic             host_enable,
    input  logic             host_disable,
    input  logic             host_lock,
    input  logic             host_unlock,
    input  logic             irq_clr,
    input  logic             slot_start,
    input  logic             slot_assigned,
    input  logic             tx_done,
    output logic             stat_disabled,
    output logic             stat_locked,
    output logic             host_access_ok,
    output logic             commit_cmt,
    output logic [IDX_W-1:0] commit_idx,
    output logic             tx_cmt,
    output logic             tx_dval,
    output logic [IDX_W-1:0] tx_idx,
    output logic             tx_active,
    output logic             null_slot,
    output logic             xfer_busy,
    output logic             irq_flag
);

    localparam logic [IDX_W-1:0] C_RST = IDX_W'(COMMIT_IDX_RST);
    localparam logic [IDX_W-1:0] T_RST = IDX_W'(TX_IDX_RST);

    typedef struct packed {
        logic             dis;
        logic             lck;
        logic             cmt_c;
        logic             irq;
        logic             tx_cmt;
        logic [IDX_W-1:0] idx_c;
        logic [IDX_W-1:0] idx_t;
    } buf_state_t;

    buf_state_t st_d, st_q;
    host_req_t  req, apply;
    logic       busy, swap_now, start_now, block_now;
    logic       tx_beg, tx_act, tx_dv, tx_nul, msg_avail, open_q, mode_ok;

    assign req       = '{dis: host_disable, en: host_enable,
                         lock: host_lock, unlock: host_unlock};
    assign open_q    = ~st_q.dis & ~st_q.lck;
    assign msg_avail = st_q.tx_cmt & ~st_q.dis & ~busy;
    assign mode_ok   = mode_immediate | ~st_q.tx_cmt | tx_dv;
    assign start_now = ~busy & open_q & st_q.cmt_c & ~tx_act & ~tx_beg & mode_ok;
    assign block_now = busy | start_now;

    tx_swap_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .block_i (block_now),
        .apply_o (apply)
    );

    tx_swap_xfer u_xfer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_now),
        .busy_o  (busy),
        .swap_o  (swap_now)
    );

    tx_swap_txside u_txs (
        .clk             (clk),
        .rst_n           (rst_n),
        .slot_start_i    (slot_start),
        .slot_assigned_i (slot_assigned),
        .tx_done_i       (tx_done),
        .msg_avail_i     (msg_avail),
        .swap_i          (swap_now),
        .begin_o         (tx_beg),
        .active_o        (tx_act),
        .dval_o          (tx_dv),
        .null_o          (tx_nul)
    );

    always_comb begin
        st_d = st_q;
        if (apply.dis)         st_d.dis = 1'b1;
        else if (apply.en)     st_d.dis = 1'b0;
        if (apply.lock)        st_d.lck = 1'b1;
        else if (apply.unlock) st_d.lck = 1'b0;
        if (!open_q) begin
            if (host_commit_set)      st_d.cmt_c = 1'b1;
            else if (host_commit_clr) st_d.cmt_c = 1'b0;
        end
        if (irq_clr) st_d.irq = 1'b0;
        if (swap_now) begin
            st_d.idx_c  = st_q.idx_t;
            st_d.idx_t  = st_q.idx_c;
            st_d.cmt_c  = 1'b0;
            st_d.irq    = 1'b1;
            st_d.tx_cmt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{dis: 1'b1, lck: 1'b0, cmt_c: 1'b0, irq: 1'b0,
                      tx_cmt: 1'b0, idx_c: C_RST, idx_t: T_RST};
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_disabled  = st_q.dis;
    assign stat_locked    = st_q.lck;
    assign host_access_ok = ~open_q;
    assign commit_cmt     = st_q.cmt_c;
    assign commit_idx     = st_q.idx_c;
    assign tx_cmt         = st_q.tx_cmt;
    assign tx_dval        = tx_dv;
    assign tx_idx         = st_q.idx_t;
    assign tx_active      = tx_act;
    assign null_slot      = tx_nul;
    assign xfer_busy      = busy;
    assign irq_flag       = st_q.irq;

endmodule

// File: rtl/tx_swap_buf_chk.sv
module tx_swap_buf_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_immediate,
    input logic             stat_disabled,
    input logic             stat_locked,
    input logic             commit_cmt,
    input logic [IDX_W-1:0] commit_idx,
    input logic             tx_cmt,
    input logic             tx_dval,
    input logic [IDX_W-1:0] tx_idx,
    input logic             tx_active,
    input logic             null_slot,
    input logic             xfer_busy,
    input logic             irq_flag
);

    AST_SWAP_INDICES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |=> (tx_idx == $past(commit_idx)) && (commit_idx == $past(tx_idx))); // R3

    AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |=> !commit_cmt && irq_flag && tx_cmt && !tx_dval); // R3

    AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |=> xfer_busy ##1 !xfer_busy); // R4

    AST_STREAM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_immediate && tx_cmt && !tx_dval && !xfer_busy) |=> !xfer_busy); // R5

    AST_NO_XFER_DURING_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_active && xfer_busy)); // R6

    AST_COMMIT_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_disabled && !stat_locked) |=> !$rose(commit_cmt)); // R2

    AST_NULL_OR_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !(null_slot && $rose(tx_active))); // R8

endmodule

bind tx_swap_buf tx_swap_buf_chk #(.IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mode_immediate (mode_immediate),
    .stat_disabled  (stat_disabled),
    .stat_locked    (stat_locked),
    .commit_cmt     (commit_cmt),
    .commit_idx     (commit_idx),
    .tx_cmt         (tx_cmt),
    .tx_dval        (tx_dval),
    .tx_idx         (tx_idx),
    .tx_active      (tx_active),
    .null_slot      (null_slot),
    .xfer_busy      (xfer_busy),
    .irq_flag       (irq_flag)
);

// File: tb/tx_swap_buf_tb.sv
`timescale 1ns/1ps
module tx_swap_buf_tb;

    localparam int IDX_W = 4;
    localparam real CLK_P = 20.0;

    localparam logic [8:0] P_CSET = 9'h001;
    localparam logic [8:0] P_CCLR = 9'h002;
    localparam logic [8:0] P_EN   = 9'h004;
    localparam logic [8:0] P_DIS  = 9'h008;
    localparam logic [8:0] P_LOCK = 9'h010;
    localparam logic [8:0] P_UNLK = 9'h020;
    localparam logic [8:0] P_ICLR = 9'h040;
    localparam logic [8:0] P_SLOT = 9'h080;
    localparam logic [8:0] P_DONE = 9'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_immediate = 1'b0;
    logic host_commit_set = 1'b0, host_commit_clr = 1'b0;
    logic host_enable = 1'b0, host_disable = 1'b0;
    logic host_lock = 1'b0, host_unlock = 1'b0;
    logic irq_clr = 1'b0, slot_start = 1'b0, slot_assigned = 1'b0, tx_done = 1'b0;
    logic stat_disabled, stat_locked, host_access_ok, commit_cmt;
    logic [IDX_W-1:0] commit_idx, tx_idx;
    logic tx_cmt, tx_dval, tx_active, null_slot, xfer_busy, irq_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    tx_swap_buf #(.IDX_W(IDX_W), .COMMIT_IDX_RST(0), .TX_IDX_RST(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_immediate(mode_immediate),
        .host_commit_set(host_commit_set), .host_commit_clr(host_commit_clr),
        .host_enable(host_enable), .host_disable(host_disable),
        .host_lock(host_lock), .host_unlock(host_unlock), .irq_clr(irq_clr),
        .slot_start(slot_start), .slot_assigned(slot_assigned), .tx_done(tx_done),
        .stat_disabled(stat_disabled), .stat_locked(stat_locked),
        .host_access_ok(host_access_ok), .commit_cmt(commit_cmt),
        .commit_idx(commit_idx), .tx_cmt(tx_cmt), .tx_dval(tx_dval),
        .tx_idx(tx_idx), .tx_active(tx_active), .null_slot(null_slot),
        .xfer_busy(xfer_busy), .irq_flag(irq_flag)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic apply(input logic [8:0] v);
        host_commit_set = v[0];
        host_commit_clr = v[1];
        host_enable     = v[2];
        host_disable    = v[3];
        host_lock       = v[4];
        host_unlock     = v[5];
        irq_clr         = v[6];
        slot_start      = v[7];
        slot_assigned   = v[7];
        tx_done         = v[8];
        cyc();
        {host_commit_set, host_commit_clr, host_enable, host_disable, host_lock,
         host_unlock, irq_clr, slot_start, slot_assigned, tx_done} = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    // Reset, enable, first commit and exchange: transmit half then holds index 0, tx_cmt=1.
    task automatic prime(input logic mode);
        mode_immediate = mode;
        do_reset();
        apply(P_EN);
        apply(P_LOCK);
        apply(P_CSET);
        apply(P_UNLK);
        apply('0); apply('0); apply('0);
    endtask

    task automatic recommit();
        apply(P_LOCK);
        apply(P_CSET);
        apply(P_UNLK);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "disabled", stat_disabled, 1);
        chk("R1", "locked", stat_locked, 0);
        chk("R1", "commit_cmt", commit_cmt, 0);
        chk("R1", "commit_idx", commit_idx, 0);
        chk("R1", "tx_idx", tx_idx, 1);
        chk("R1", "tx_cmt/dval", {tx_cmt, tx_dval}, 0);
        chk("R1", "busy/irq/act/null", {xfer_busy, irq_flag, tx_active, null_slot}, 0);

        // R8 owned slot with nothing to send gives a null slot
        apply(P_SLOT);
        chk("R8", "null_slot empty", null_slot, 1);
        chk("R8", "no tx when empty", tx_active, 0);
        apply('0);
        chk("R8", "null one cycle", null_slot, 0);

        // R2 commit ignored in open state
        apply(P_EN);
        chk("R2", "access closed", host_access_ok, 0);
        apply(P_CSET);
        chk("R2", "commit ignored", commit_cmt, 0);
        apply('0);
        chk("R2", "no exchange", xfer_busy, 0);
        apply(P_LOCK);
        chk("R2", "access when locked", host_access_ok, 1);
        apply(P_CSET);
        chk("R2", "commit accepted", commit_cmt, 1);

        // R4 / R3 exchange timing and effects
        apply(P_UNLK);
        chk("R4", "no busy at unlock edge", xfer_busy, 0);
        apply('0);
        chk("R4", "busy first cycle", xfer_busy, 1);
        chk("R4", "no trade yet", tx_idx, 1);
        apply('0);
        chk("R4", "busy second cycle", xfer_busy, 1);
        chk("R3", "tx_idx traded", tx_idx, 0);
        chk("R3", "commit_idx traded", commit_idx, 1);
        chk("R3", "flags cmt/irq/txcmt/dval", {commit_cmt, irq_flag, tx_cmt, tx_dval}, 4'b0110);
        apply('0);
        chk("R4", "busy falls", xfer_busy, 0);

        // R12 interrupt clear
        apply(P_ICLR);
        chk("R12", "irq cleared", irq_flag, 0);

        // R8/R10 message available: transmission, then done
        apply(P_SLOT);
        chk("R8", "tx started", tx_active, 1);
        chk("R8", "no null", null_slot, 0);
        apply(P_DONE);
        chk("R10", "tx ended", tx_active, 0);
        chk("R10", "dval set", tx_dval, 1);

        // R5/R6 sweep: mode x transmit-half history
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
                logic exp_go;
                exp_go = (m != 0) || (s != 0);
                prime(m[0]);
                if (s != 0) begin apply(P_SLOT); apply(P_DONE); end
                recommit();
                apply('0);
                chk(m ? "R6" : "R5", $sformatf("busy m=%0d s=%0d", m, s),
                    xfer_busy, exp_go);
                apply('0);
                chk(m ? "R6" : "R5", $sformatf("tx_idx m=%0d s=%0d", m, s),
                    tx_idx, exp_go ? 1 : 0);
                if (!exp_go) begin
                    apply(P_SLOT);
                    apply(P_DONE);
                    apply('0);
                    chk("R5", "released after send", xfer_busy, 1);
                    apply('0);
                    chk("R5", "tx_idx after send", tx_idx, 1);
                end
            end
        end

        // R6 immediate mode waits for transmission in flight
        prime(1'b1);
        apply(P_LOCK);
        apply(P_CSET);
        apply(P_SLOT);
        chk("R6", "tx while locked", tx_active, 1);
        apply(P_UNLK);
        apply('0);
        chk("R6", "no exchange during tx", xfer_busy, 0);
        apply(P_DONE);
        chk("R6", "busy low at done edge", xfer_busy, 0);
        apply('0);
        chk("R6", "exchange after done", xfer_busy, 1);

        // R9 transmission start beats exchange start
        prime(1'b0);
        apply(P_SLOT); apply(P_DONE);
        recommit();
        apply(P_SLOT);
        chk("R9", "tx wins", tx_active, 1);
        chk("R9", "exchange waits", xfer_busy, 0);
        apply(P_DONE);
        apply('0);
        chk("R9", "exchange after tx", xfer_busy, 1);

        // R7 requests held across an exchange
        prime(1'b0);
        apply(P_SLOT); apply(P_DONE);
        recommit();
        apply(P_LOCK);
        chk("R7", "busy on start", xfer_busy, 1);
        chk("R7", "lock held", stat_locked, 0);
        apply(P_DIS);
        chk("R7", "disable held", stat_disabled, 0);
        apply('0);
        chk("R7", "still held after busy", {stat_disabled, stat_locked}, 0);
        apply('0);
        chk("R7", "applied afterwards", {stat_disabled, stat_locked}, 2'b11);

        // R11 status priorities
        apply(P_EN | P_DIS);
        chk("R11", "disable wins", stat_disabled, 1);
        apply(P_EN);
        chk("R11", "enabled, still locked", {stat_disabled, stat_locked}, 2'b01);
        apply(P_LOCK | P_UNLK);
        chk("R11", "lock wins", stat_locked, 1);
        apply(P_CCLR);
        chk("R2", "clear while locked", commit_cmt, 0);
        apply(P_UNLK);
        chk("R11", "unlocked", stat_locked, 0);

        summary();
        $finish;
    end

endmodule